// File: doc/BRIEF.md
# ADC Scan Sequencer with Overrun Pause

This block sequences a multi-channel analog-to-digital conversion scan. Software programs a first and a last channel and picks one of three modes: a one-shot scan, a free-running scan that wraps back to the first channel, or a step mode that converts one channel per start pulse. The converter itself sits outside the block and is reached through a request/done handshake that returns a data word. Every accepted result goes into a per-channel result bank and into a single latest-result register.

Two interrupt flags, each with its own enable, report progress. The conversion flag rises after every stored result and the scan flag rises after the last channel's result. Each flag doubles as a DMA request, and a DMA acknowledge (or a software clear) clears only its own flag. To keep unread data from being overwritten, the sequencer holds a finished result back and pauses while the relevant flag is still pending. In free-running mode with the scan flag enabled, the whole bank is guarded at the start of each new pass. In every other setting, the latest-result register is guarded after each conversion.

Top module: `adc_scan_seq`

## Requirements
- R1: Channels are converted in ascending order from `start_ch` to `end_ch`; in continuous mode the scan wraps from the last channel back to `start_ch`.
- R2: Each stored result is written to bank entry `conv_ch` and to `latest`; `rd_data` shows bank entry `rd_ch` one clock after `rd_ch` is applied.
- R3: `eoc_irq` is set on each stored result when `eoc_en` is 1 and is never set when `eoc_en` is 0.
- R4: `eos_irq` is set when the last channel's result is stored and `eos_en` is 1; with both enables on, both flags are set by that same result.
- R5: In continuous mode with `eos_en` = 1, a result for `start_ch` that arrives while `eos_irq` is set is held back: `pause` goes to 1 and the bank entry keeps its old value.
- R6: In single or step mode, or in continuous mode with `eos_en` = 0, any result that arrives while `eoc_irq` is set is held back: `pause` goes to 1 and `latest` keeps its old value.
- R7: While paused, `conv_req` stays low. Once the blocking flag reads 0, the held result is stored on the next clock, `pause` returns to 0 and the scan continues.
- R8: `stat_a` = {busy, eoc_en, eoc_irq, pause, 2'b00, mode}. `stat_b[7:4]` mirrors `stat_a[7:4]`, and `stat_b[3:0]` = {eos_en, eos_irq, 2'b00}.
- R9: `eoc_clr` or `dma_ack_eoc` clears only `eoc_irq`; `eos_clr` or `dma_ack_eos` clears only `eos_irq`. A set in the same cycle takes priority over a clear.
- R10: If `end_ch` < `start_ch`, only `start_ch` is converted, and it counts as the last channel.
- R11: A `sw_start` pulse begins a scan. A `sw_stop` pulse ends it after the current result is stored. `busy` is 1 while a scan is converting or paused.
- R12: `mode` encoding: 2'b00 single pass, 2'b01 continuous, 2'b10 step. In step mode each `sw_start` converts one channel and then idles; the next start resumes at the following channel, and after the last channel it wraps to `start_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Scan mode (see R12) |
| start_ch | input | CHW | First channel of the scan |
| end_ch | input | CHW | Last channel of the scan |
| eoc_en | input | 1 | Enable for the per-conversion flag |
| eos_en | input | 1 | Enable for the end-of-scan flag |
| sw_start | input | 1 | Start pulse |
| sw_stop | input | 1 | Stop pulse, takes effect at the next result boundary |
| eoc_clr | input | 1 | Software clear of eoc_irq |
| eos_clr | input | 1 | Software clear of eos_irq |
| dma_ack_eoc | input | 1 | DMA acknowledge for the conversion request |
| dma_ack_eos | input | 1 | DMA acknowledge for the scan request |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | CHW | Channel being converted |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | DW | Converter result, valid with conv_done |
| rd_ch | input | CHW | Bank read address |
| rd_data | output | DW | Bank read data, one clock latency |
| latest | output | DW | Most recent stored result |
| eoc_irq | output | 1 | Per-conversion flag, also a DMA request |
| eos_irq | output | 1 | End-of-scan flag, also a DMA request |
| pause | output | 1 | A result is held back |
| busy | output | 1 | Scan converting or paused |
| stat_a | output | 8 | Primary status byte |
| stat_b | output | 8 | Secondary status byte with mirrored upper half |

## Verification
A `conv_done` accepted on one edge is stored on the following edge, so `latest` and the flags are sampled at the falling edge after that store. A flag clear takes effect on its own edge and the held result is stored one edge later, which is why every pause release is checked at the second falling edge after the clear pulse begins. Bank reads are sampled one full clock after `rd_ch` is set. The converter model logs every channel and data word it returns, so the order, the wrap, the pause holds and the stop boundary are all checked against that log.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_STEP   = 2'b10
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_HOLD
  } scan_state_e;
endpackage

// File: rtl/result_bank.sv
module result_bank #(
  parameter int DW    = 10,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_eoc,
  input  logic set_eos,
  input  logic clr_eoc,
  input  logic clr_eos,
  output logic eoc_flag,
  output logic eos_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_flag <= 1'b0;
      eos_flag <= 1'b0;
    end else begin
      if (set_eoc)      eoc_flag <= 1'b1;
      else if (clr_eoc) eoc_flag <= 1'b0;
      if (set_eos)      eos_flag <= 1'b1;
      else if (clr_eos) eos_flag <= 1'b0;
    end
  end

  assert_eoc_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_eoc && !set_eoc) |=> !eoc_flag);
  assert_eos_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_eos && !set_eos) |=> !eos_flag);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode,
  input  logic [CHW-1:0] start_ch,
  input  logic [CHW-1:0] end_ch,
  input  logic           eos_en,
  input  logic           sw_start,
  input  logic           sw_stop,
  input  logic           eoc_flag,
  input  logic           eos_flag,
  input  logic           conv_done,
  output logic           conv_req,
  output logic [CHW-1:0] conv_ch,
  output logic           busy,
  output logic           pause,
  output logic           wr_en,
  output logic           wr_last
);
  scan_state_e    state;
  scan_mode_e     md;
  logic [CHW-1:0] cur_ch;
  logic [CHW-1:0] end_eff;
  logic           abort;
  logic           step_mid;
  logic           guard_bank;
  logic           blocked;
  logic           quit;

  assign md         = scan_mode_e'(mode);
  assign end_eff    = (end_ch < start_ch) ? start_ch : end_ch;
  assign guard_bank = (md == MODE_CONT) && eos_en;
  assign blocked    = guard_bank ? ((cur_ch == start_ch) && eos_flag) : eoc_flag;
  assign wr_en      = (state == ST_HOLD) && !blocked;
  assign wr_last    = (cur_ch == end_eff);
  assign quit       = abort || sw_stop;
  assign conv_req   = (state == ST_CONV);
  assign conv_ch    = cur_ch;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_ch   <= '0;
      pause    <= 1'b0;
      abort    <= 1'b0;
      step_mid <= 1'b0;
    end else begin
      if (sw_stop && state != ST_IDLE) abort <= 1'b1;
      case (state)
        ST_IDLE: begin
          abort <= 1'b0;
          if (sw_start) begin
            state <= ST_CONV;
            if (!(md == MODE_STEP && step_mid)) cur_ch <= start_ch;
          end
        end
        ST_CONV: if (conv_done) state <= ST_HOLD;
        ST_HOLD: begin
          if (blocked) begin
            pause <= 1'b1;
          end else begin
            pause <= 1'b0;
            if (wr_last) begin
              step_mid <= 1'b0;
              cur_ch   <= start_ch;
              state    <= (md == MODE_CONT && !quit) ? ST_CONV : ST_IDLE;
            end else begin
              cur_ch <= cur_ch + 1'b1;
              if (quit) begin
                step_mid <= 1'b0;
                state    <= ST_IDLE;
              end else if (md == MODE_STEP) begin
                step_mid <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                state <= ST_CONV;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_req_while_paused_R7: assert property (@(posedge clk) disable iff (rst)
    pause |-> !conv_req);
  assert_ch_in_window_R1: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (conv_ch >= start_ch && conv_ch <= end_eff));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 32,
  parameter int DW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode,
  input  logic [CHW-1:0] start_ch,
  input  logic [CHW-1:0] end_ch,
  input  logic           eoc_en,
  input  logic           eos_en,
  input  logic           sw_start,
  input  logic           sw_stop,
  input  logic           eoc_clr,
  input  logic           eos_clr,
  input  logic           dma_ack_eoc,
  input  logic           dma_ack_eos,
  output logic           conv_req,
  output logic [CHW-1:0] conv_ch,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  latest,
  output logic           eoc_irq,
  output logic           eos_irq,
  output logic           pause,
  output logic           busy,
  output logic [7:0]     stat_a,
  output logic [7:0]     stat_b
);
  logic          wr_en;
  logic          wr_last;
  logic [DW-1:0] held;

  scan_ctrl #(.CHW(CHW)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .start_ch(start_ch), .end_ch(end_ch),
    .eos_en(eos_en), .sw_start(sw_start), .sw_stop(sw_stop),
    .eoc_flag(eoc_irq), .eos_flag(eos_irq), .conv_done(conv_done),
    .conv_req(conv_req), .conv_ch(conv_ch), .busy(busy), .pause(pause),
    .wr_en(wr_en), .wr_last(wr_last)
  );

  irq_flags u_flags (
    .clk(clk), .rst(rst),
    .set_eoc(wr_en && eoc_en),
    .set_eos(wr_en && wr_last && eos_en),
    .clr_eoc(eoc_clr || dma_ack_eoc),
    .clr_eos(eos_clr || dma_ack_eos),
    .eoc_flag(eoc_irq), .eos_flag(eos_irq)
  );

  result_bank #(.DW(DW), .DEPTH(NCH)) u_bank (
    .clk(clk), .we(wr_en), .wa(conv_ch), .wd(held), .ra(rd_ch), .rd(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      latest <= '0;
    end else begin
      if (conv_req && conv_done) held <= conv_data;
      if (wr_en) latest <= held;
    end
  end

  assign stat_a = {busy, eoc_en, eoc_irq, pause, 2'b00, mode};
  assign stat_b = {stat_a[7:4], eos_en, eos_irq, 2'b00};

  assert_latest_frozen_on_pause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pause) |-> $stable(latest));
  assert_eos_only_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(eos_irq) |-> $past(wr_en && wr_last && eos_en));
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int NCH = 32;
  localparam int DW  = 10;
  localparam int CHW = 5;

  logic clk = 0, rst = 1;
  logic [1:0] mode = 2'b00;
  logic [CHW-1:0] start_ch = 0, end_ch = 0, rd_ch = 0;
  logic eoc_en = 0, eos_en = 0, sw_start = 0, sw_stop = 0;
  logic eoc_clr = 0, eos_clr = 0, dma_ack_eoc = 0, dma_ack_eos = 0;
  logic conv_done = 0;
  logic [DW-1:0] conv_data = 0;
  logic conv_req, eoc_irq, eos_irq, pause, busy;
  logic [CHW-1:0] conv_ch;
  logic [DW-1:0] rd_data, latest;
  logic [7:0] stat_a, stat_b;

  int checks = 0, errors = 0, n_conv = 0, lat = 0;
  logic [CHW-1:0] ch_log [0:255];
  logic [DW-1:0]  dat_log [0:255];

  adc_scan_seq #(.NCH(NCH), .DW(DW)) u_dut (.*);

  always #10 clk = ~clk;

  // converter model: answers each request three falling edges later
  initial forever begin
    @(negedge clk);
    conv_done = 0;
    if (conv_req) begin
      lat++;
      if (lat == 3) begin
        conv_done = 1;
        conv_data = {n_conv[4:0], conv_ch};
        ch_log[n_conv]  = conv_ch;
        dat_log[n_conv] = {n_conv[4:0], conv_ch};
        n_conv++;
        lat = 0;
      end
    end else lat = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_pause();
    for (int i = 0; i < 2000 && !pause; i++) @(negedge clk);
  endtask

  task automatic read_bank(input logic [CHW-1:0] ch, output logic [DW-1:0] v);
    rd_ch = ch;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    chk("R11 reset busy", busy, 0);
    chk("R7 reset conv_req", conv_req, 0);
    chk("R3 reset flags", {eoc_irq, eos_irq, pause}, 0);
    chk("R2 reset latest", latest, 0);
  endtask

  task automatic t_single();
    int n0;
    logic [DW-1:0] v;
    n0 = n_conv;
    mode = 2'b00; start_ch = 2; end_ch = 5; eoc_en = 0; eos_en = 1;
    @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
    chk("R11 busy after start", busy, 1);
    wait_idle();
    chk("R1 count", n_conv - n0, 4);
    for (int k = 0; k < 4; k++) chk("R1 order", ch_log[n0+k], 2 + k);
    chk("R2 latest", latest, dat_log[n0+3]);
    read_bank(3, v);
    chk("R2 bank ch3", v, dat_log[n0+1]);
    chk("R4 eos set", eos_irq, 1);
    chk("R3 eoc off", eoc_irq, 0);
    @(negedge clk) eos_clr = 1; @(negedge clk) eos_clr = 0;
    chk("R9 eos_clr", eos_irq, 0);
  endtask

  task automatic t_reverse();
    int n0;
    n0 = n_conv;
    mode = 2'b00; start_ch = 6; end_ch = 3; eos_en = 1; eoc_en = 0;
    @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
    wait_idle();
    chk("R10 one conversion", n_conv - n0, 1);
    chk("R10 channel", ch_log[n0], 6);
    chk("R10 eos", eos_irq, 1);
    @(negedge clk) dma_ack_eos = 1; @(negedge clk) dma_ack_eos = 0;
    chk("R9 dma eos", eos_irq, 0);
  endtask

  task automatic t_eoc_guard();
    int n0;
    n0 = n_conv;
    mode = 2'b00; start_ch = 0; end_ch = 2; eoc_en = 1; eos_en = 1;
    @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
    wait_pause();
    chk("R6 paused", pause, 1);
    chk("R6 latest kept", latest, dat_log[n0]);
    chk("R3 eoc set", eoc_irq, 1);
    chk("R8 mirror", stat_b[7:4], stat_a[7:4]);
    chk("R8 stat_a", stat_a, 8'b1111_0000);
    repeat (5) @(negedge clk);
    chk("R7 no request", conv_req, 0);
    chk("R11 busy paused", busy, 1);
    chk("R6 still kept", latest, dat_log[n0]);
    @(negedge clk) eoc_clr = 1; @(negedge clk) eoc_clr = 0;
    @(negedge clk);
    chk("R7 release write", latest, dat_log[n0+1]);
    chk("R7 pause cleared", pause, 0);
    wait_pause();
    @(negedge clk) dma_ack_eoc = 1; @(negedge clk) dma_ack_eoc = 0;
    @(negedge clk);
    chk("R7 dma release", latest, dat_log[n0+2]);
    chk("R4 both flags", {eoc_irq, eos_irq}, 2'b11);
    @(negedge clk) dma_ack_eoc = 1; @(negedge clk) dma_ack_eoc = 0;
    chk("R9 only eoc cleared", {eoc_irq, eos_irq}, 2'b01);
    @(negedge clk) eos_clr = 1; @(negedge clk) eos_clr = 0;
    chk("R11 single done", busy, 0);
    chk("R8 stat_b idle", stat_b, 8'b0100_1000);
  endtask

  task automatic t_cont_guard();
    int n0;
    logic [DW-1:0] v;
    n0 = n_conv;
    mode = 2'b01; start_ch = 4; end_ch = 7; eoc_en = 0; eos_en = 1;
    @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
    wait_pause();
    chk("R5 paused", pause, 1);
    chk("R1 wrap channel", ch_log[n0+4], 4);
    read_bank(4, v);
    chk("R5 bank kept", v, dat_log[n0]);
    chk("R7 no request", conv_req, 0);
    @(negedge clk) dma_ack_eos = 1; @(negedge clk) dma_ack_eos = 0;
    @(negedge clk);
    read_bank(4, v);
    chk("R7 bank written", v, dat_log[n0+4]);
    @(negedge clk) sw_stop = 1; @(negedge clk) sw_stop = 0;
    wait_idle();
    chk("R11 stopped", busy, 0);
    chk("R11 stop boundary", (n_conv - n0) <= 6, 1);
    repeat (10) @(negedge clk);
    chk("R11 no restart", conv_req, 0);
    @(negedge clk) eos_clr = 1; @(negedge clk) eos_clr = 0;
  endtask

  task automatic t_step();
    int n0;
    n0 = n_conv;
    mode = 2'b10; start_ch = 1; end_ch = 2; eoc_en = 0; eos_en = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
      wait_idle();
      chk("R12 one per start", n_conv - n0, k + 1);
      chk("R12 latest", latest, dat_log[n0+k]);
    end
    chk("R12 ch a", ch_log[n0], 1);
    chk("R12 ch b", ch_log[n0+1], 2);
    chk("R12 wrap", ch_log[n0+2], 1);
    chk("R3 eoc never", eoc_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_reverse();
    t_eoc_guard();
    t_cont_guard();
    t_step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule